// File: doc/BRIEF.md
# Buffered PWM Channel Counter

This block is one pulse-width modulation channel built around an 8-bit counter. The counter advances on a one-cycle tick that an external prescaler supplies. It runs in one of two alignments. In left alignment it counts upward and wraps. In center alignment it climbs to the period value and then descends back to zero. The output is high or low depending on where the count stands relative to the duty value, and a polarity input chooses which level is active.

Software writes period and duty values into buffer registers. The counter and the comparator never see these buffers directly. Each buffer reaches its active register only at a safe point, so a new setting never produces a torn cycle:
- the end of an effective period,
- a write to the counter,
- any cycle in which the channel is disabled.

A counter write strobe restarts the channel at once. The counter readback is a plain port, so reading it has no side effects.

Top module: `pwm_chan_buffered`

## Requirements
- R1: The counter changes only on a clock edge where `tick` and `chan_en` are both 1, or where `cnt_wr` is 1. Otherwise `cnt_q` keeps its value.
- R2: In left alignment (`center_sel`=0) with an active period P>0, the count steps 0,1,…,P-1 and then returns to 0. That return is the end of the effective period.
- R3: In center alignment (`center_sel`=1) with an active period P>0, the count steps 0,1,…,P,P-1,…,1,0, a cycle of 2·P ticks. Reaching 0 on the way down is the end of the effective period, and the count then climbs again.
- R4: A `cnt_wr` strobe works whether or not the channel is enabled and whether or not a tick is present. On the next edge it sets the count to 0 and the direction to up. It also copies both buffers into the active registers on that edge, including a period or duty value written in the same cycle.
- R5: While the channel is enabled, a period or duty write changes only the buffer. The active value in use stays the same until the next end of period (R2, R3) or the next counter write (R4).
- R6: While `chan_en`=0, the count and direction hold, and the active registers follow the buffers on every edge. When the channel is enabled again, counting resumes from the held count.
- R7: Let the active period be P, the active duty D and the count C. The channel is active when P>0 and C<D. With `pol`=1 the active level is 1, and with `pol`=0 it is 0. The `pwm_o` output shows the level for the count currently on `cnt_q`, and `pol` acts on it without delay.
- R8: In center alignment the same C<D rule applies on both slopes. The output therefore changes at the duty match while counting up and again while counting down.
- R9: An active period of 0 holds `pwm_o` at the inactive level. The counter is then held at 0.
- R10: An active duty greater than or equal to a nonzero active period holds `pwm_o` at the active level for every count of the period, including the top count in center alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable pulse from the prescaler |
| chan_en | input | 1 | Channel enable |
| center_sel | input | 1 | 1 = center alignment, 0 = left alignment |
| pol | input | 1 | 1 = active level high, 0 = active level low |
| per_wr | input | 1 | Write strobe for the period buffer |
| per_wdata | input | 8 | Period value to buffer |
| duty_wr | input | 1 | Write strobe for the duty buffer |
| duty_wdata | input | 8 | Duty value to buffer |
| cnt_wr | input | 1 | Counter write strobe (restart and reload) |
| cnt_q | output | 8 | Counter readback |
| pwm_o | output | 1 | PWM output |

## Verification
The output is first checked with a continuous tick in left alignment and then with a gapped tick. Comparing the two separates counting on the tick from counting on the clock. Period and duty are rewritten in the middle of a period, and the run is checked to keep the old values until the wrap. A stretch with the channel disabled followed by a resume shows that the count holds rather than restarts. A counter write while enabled is combined with a same-cycle period write to show the immediate reload. Center runs with a middle duty, a duty at or above the period, and a zero period separate the two-slope comparison from its saturating corner cases, and both polarities are applied.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } pwm_dir_e;
endpackage

// File: rtl/pwm_shadow_reg.sv
// Buffer plus active register pair for one channel setting.
module pwm_shadow_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] buf_nxt,
  output logic [W-1:0] act_nxt,
  output logic [W-1:0] act_q
);
  logic [W-1:0] buf_q;

  // Buffer value after this edge, so a same-cycle write is seen by a load.
  assign buf_nxt = wr ? wdata : buf_q;
  assign act_nxt = load ? buf_nxt : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_nxt;
      act_q <= act_nxt;
    end
  end
endmodule

// File: rtl/pwm_counter.sv
// Up or up/down counter with end-of-period detection.
module pwm_counter
  import pwm_chan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         chan_en,
  input  logic         center_sel,
  input  logic         cnt_wr,
  input  logic [W-1:0] per_act,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output pwm_dir_e     dir_q,
  output logic         end_evt
);
  localparam logic [W-1:0] ONE = W'(1);

  pwm_dir_e dir_nxt;
  logic     step;

  // Left alignment wraps when the next count would reach the period.
  function automatic logic left_wrap(input logic [W-1:0] c, input logic [W-1:0] p);
    logic [W:0] inc;
    inc = {1'b0, c} + {{W{1'b0}}, 1'b1};
    return inc >= {1'b0, p};
  endfunction

  // Center alignment keeps climbing while below the top.
  function automatic logic center_climb(input pwm_dir_e d, input logic [W-1:0] c,
                                        input logic [W-1:0] p);
    return (d == DIR_UP) && (c < p);
  endfunction

  assign step = chan_en && tick;

  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    end_evt = 1'b0;
    if (cnt_wr) begin
      cnt_nxt = '0;
      dir_nxt = DIR_UP;
    end else if (step) begin
      if (!center_sel) begin
        dir_nxt = DIR_UP;
        if (left_wrap(cnt_q, per_act)) begin
          cnt_nxt = '0;
          end_evt = 1'b1;
        end else begin
          cnt_nxt = cnt_q + ONE;
        end
      end else if (center_climb(dir_q, cnt_q, per_act)) begin
        cnt_nxt = cnt_q + ONE;
      end else if ((per_act == '0) || (cnt_q <= ONE)) begin
        cnt_nxt = '0;
        dir_nxt = DIR_UP;
        end_evt = 1'b1;
      end else begin
        cnt_nxt = cnt_q - ONE;
        dir_nxt = DIR_DN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_nxt;
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
// Registered active flag plus polarity mapping.
module pwm_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_nxt,
  input  logic [W-1:0] duty_nxt,
  input  logic [W-1:0] per_nxt,
  input  logic         pol,
  output logic         act_q,
  output logic         pwm_o
);
  function automatic logic active_level(input logic [W-1:0] c, input logic [W-1:0] d,
                                        input logic [W-1:0] p);
    if (p == '0) return 1'b0;
    if (d >= p)  return 1'b1;
    return c < d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= active_level(cnt_nxt, duty_nxt, per_nxt);
  end

  assign pwm_o = pol ? act_q : ~act_q;
endmodule

// File: rtl/pwm_chan_buffered.sv
module pwm_chan_buffered
  import pwm_chan_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         chan_en,
  input  logic         center_sel,
  input  logic         pol,
  input  logic         per_wr,
  input  logic [W-1:0] per_wdata,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_wdata,
  input  logic         cnt_wr,
  output logic [W-1:0] cnt_q,
  output logic         pwm_o
);
  logic [W-1:0] per_act, per_nxt, per_eff_nxt;
  logic [W-1:0] duty_act, duty_nxt, duty_eff_nxt;
  logic [W-1:0] cnt_nxt;
  pwm_dir_e     dir_q;
  logic         dir_dn;
  logic         end_evt;
  logic         load_evt;
  logic         act_q;

  assign load_evt = cnt_wr || end_evt || !chan_en;
  assign dir_dn   = (dir_q == DIR_DN);

  pwm_shadow_reg #(.W(W)) u_per (
    .clk(clk), .rst_n(rst_n), .wr(per_wr), .wdata(per_wdata), .load(load_evt),
    .buf_nxt(per_nxt), .act_nxt(per_eff_nxt), .act_q(per_act)
  );

  pwm_shadow_reg #(.W(W)) u_duty (
    .clk(clk), .rst_n(rst_n), .wr(duty_wr), .wdata(duty_wdata), .load(load_evt),
    .buf_nxt(duty_nxt), .act_nxt(duty_eff_nxt), .act_q(duty_act)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en),
    .center_sel(center_sel), .cnt_wr(cnt_wr), .per_act(per_act),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .dir_q(dir_q), .end_evt(end_evt)
  );

  pwm_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt), .duty_nxt(duty_eff_nxt),
    .per_nxt(per_eff_nxt), .pol(pol), .act_q(act_q), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         chan_en,
  input logic         center_sel,
  input logic         pol,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_q,
  input logic         pwm_o,
  input logic [W-1:0] per_act,
  input logic [W-1:0] per_nxt,
  input logic         load_evt,
  input logic         dir_dn
);
  a_r1_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(cnt_q));

  a_r2_left_step: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !center_sel && tick && !cnt_wr && per_act != '0 &&
     {1'b0, cnt_q} + 1'b1 < {1'b0, per_act})
    |=> cnt_q == W'($past(cnt_q) + 1'b1));

  a_r3_center_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && center_sel && tick && !cnt_wr && !dir_dn && per_act > W'(1) &&
     cnt_q == per_act) |=> (cnt_q == W'($past(cnt_q) - 1'b1)) && dir_dn);

  a_r4_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == '0) && !dir_dn);

  a_r5_load_takes_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> per_act == $past(per_nxt));

  a_r5_no_load_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(per_act));

  a_r6_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !cnt_wr) |=> $stable(cnt_q));

  a_r9_zero_period_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act == '0) |-> (pwm_o == !pol));
endmodule

bind pwm_chan_buffered pwm_chan_checker #(.W(W)) u_chk (.*);

// File: tb/test_pwm_chan_buffered.sv
module test_pwm_chan_buffered;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, chan_en = 1'b0, center_sel = 1'b0, pol = 1'b1;
  logic       per_wr = 1'b0, duty_wr = 1'b0, cnt_wr = 1'b0;
  logic [7:0] per_wdata = '0, duty_wdata = '0;
  logic [7:0] cnt_q;
  logic       pwm_o;

  int n_checks = 0;
  int n_fails  = 0;

  // Bench-side settings applied by each step.
  logic       s_tick = 1'b0, s_en = 1'b0, s_ctr = 1'b0, s_pol = 1'b1;
  logic       s_pw = 1'b0, s_dw = 1'b0, s_cw = 1'b0;
  logic [7:0] s_pd = '0, s_dd = '0;

  // Reference state.
  int m_cnt = 0, m_per = 0, m_duty = 0, m_pbuf = 0, m_dbuf = 0;
  bit m_rising = 1'b1;

  int    q_cnt[$];
  bit    q_pwm[$];
  string q_tag[$];

  always #10 clk = ~clk;

  pwm_chan_buffered i_pwm_chan_buffered (
    .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en),
    .center_sel(center_sel), .pol(pol), .per_wr(per_wr), .per_wdata(per_wdata),
    .duty_wr(duty_wr), .duty_wdata(duty_wdata), .cnt_wr(cnt_wr),
    .cnt_q(cnt_q), .pwm_o(pwm_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // One clock of stimulus; the reference is advanced and its result queued.
  task automatic step(input string tag);
    bit fin, ld, on;
    @(negedge clk);
    tick = s_tick; chan_en = s_en; center_sel = s_ctr; pol = s_pol;
    per_wr = s_pw; per_wdata = s_pd; duty_wr = s_dw; duty_wdata = s_dd;
    cnt_wr = s_cw;
    if (s_pw) m_pbuf = s_pd;
    if (s_dw) m_dbuf = s_dd;
    fin = 1'b0;
    if (s_cw) begin
      m_cnt = 0; m_rising = 1'b1;
    end else if (s_en && s_tick) begin
      if (!s_ctr) begin
        m_rising = 1'b1;
        if (m_cnt + 1 >= m_per) begin m_cnt = 0; fin = 1'b1; end
        else m_cnt = m_cnt + 1;
      end else begin
        if (m_rising && m_cnt < m_per) m_cnt = m_cnt + 1;
        else if (m_per == 0 || m_cnt <= 1) begin m_cnt = 0; m_rising = 1'b1; fin = 1'b1; end
        else begin m_cnt = m_cnt - 1; m_rising = 1'b0; end
      end
    end
    ld = s_cw || fin || !s_en;
    if (ld) begin m_per = m_pbuf; m_duty = m_dbuf; end
    if (m_per == 0) on = 1'b0;
    else if (m_duty >= m_per) on = 1'b1;
    else on = (m_cnt < m_duty);
    q_cnt.push_back(m_cnt);
    q_pwm.push_back(s_pol ? on : !on);
    q_tag.push_back(tag);
    s_pw = 1'b0; s_dw = 1'b0; s_cw = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // Monitor: compare after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_cnt.size() != 0) begin
        int    ec;
        bit    ep;
        string t;
        ec = q_cnt.pop_front();
        ep = q_pwm.pop_front();
        t  = q_tag.pop_front();
        check({t, " count"}, int'(cnt_q), ec);
        check({t, " output"}, int'(pwm_o), int'(ep));
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R9: reset state, zero period, polarity 1 gives a low output.
    check("R9 reset count", int'(cnt_q), 0);
    check("R9 reset output", int'(pwm_o), 0);

    // R2, R7: left alignment, period 5, duty 2, polarity 1.
    s_pw = 1'b1; s_pd = 8'd5; step("R6 cfg");
    s_dw = 1'b1; s_dd = 8'd2; step("R6 cfg");
    s_en = 1'b1; s_tick = 1'b1;
    run(12, "R2");

    // R1: gapped tick.
    for (int i = 0; i < 10; i++) begin
      s_tick = (i % 2 == 0);
      step("R1");
    end
    s_tick = 1'b1;

    // R5: buffer writes mid period take effect at the wrap.
    run(2, "R5");
    s_pw = 1'b1; s_pd = 8'd4; step("R5");
    s_dw = 1'b1; s_dd = 8'd3; step("R5");
    run(12, "R5");

    // R6: disable holds count; buffers load while disabled; resume.
    s_en = 1'b0;
    run(2, "R6");
    s_dw = 1'b1; s_dd = 8'd1; step("R6");
    run(3, "R6");
    s_en = 1'b1;
    run(8, "R6");

    // R4: counter write while enabled with a same-cycle period write.
    run(2, "R4");
    s_cw = 1'b1; s_pw = 1'b1; s_pd = 8'd6; step("R4");
    run(8, "R4");

    // R7: opposite polarity.
    s_pol = 1'b0;
    run(8, "R7");

    // R3, R8: center alignment, period 4, duty 2.
    s_pol = 1'b1; s_ctr = 1'b1;
    s_pw = 1'b1; s_pd = 8'd4; step("R3");
    s_dw = 1'b1; s_dd = 8'd2; s_cw = 1'b1; step("R3");
    run(10, "R3");
    s_pol = 1'b0;
    run(10, "R8");
    s_pol = 1'b1;

    // R10: duty at and above the period.
    s_dw = 1'b1; s_dd = 8'd4; s_cw = 1'b1; step("R10");
    run(10, "R10");
    s_ctr = 1'b0;
    s_dw = 1'b1; s_dd = 8'd9; s_cw = 1'b1; step("R10");
    run(8, "R10");

    // R9: zero period while enabled, both alignments.
    s_pw = 1'b1; s_pd = 8'd0; s_cw = 1'b1; step("R9");
    run(4, "R9");
    s_ctr = 1'b1;
    run(4, "R9");

    @(posedge clk);
    #6;
    finish_run();
  end
endmodule